// File: doc/BRIEF.md
# 32-Source Interrupt Controller

The controller gathers 32 interrupt request lines and turns them into two processor-facing requests: a normal interrupt (`irq_o`) and a fast interrupt (`fiq_o`). Every line has its own sensing mode and active polarity. It is sensed either as a level or as an edge. Edge events are held in a flag until software clears them.

Software configures and observes the block through a small word-addressed register bus. The bus carries an enable mask, a polarity register, a sensing-mode register and a fast-route select register. Two status words can be read back: a raw one and a masked one. Software handles pending sources starting from the lowest bit. It acknowledges edge sources by writing ones into the raw status word.

Instances can be chained. The `irq_o` or `fiq_o` of one instance drives a source line of another instance.

Top module: `src_intc`

## Requirements
- R1: After reset the enable, polarity, mode and route words read as zero, so every source is disabled, level-sensed and active-low, and `irq_o` and `fiq_o` are low.
- R2: Word index 0 holds enable, 1 raw status, 2 masked status, 3 polarity, 4 mode and 5 route select. Enable, polarity, mode and route read back the last value written.
- R3: A source whose enable bit is 0 never drives `irq_o` or `fiq_o`.
- R4: For a source with mode bit 0 (level), the raw bit follows the input when its polarity bit is 1 and the inverted input when it is 0. The input passes through two synchronizing flops first.
- R5: For a source with mode bit 1 (edge), a rising input with polarity 1 sets a held flag, and so does a falling input with polarity 0. The raw bit shows this flag, and the flag stays set after the input returns.
- R6: Writing 1 to a bit of the raw status word clears that source's edge flag. Writing 0 leaves the flag as it was.
- R7: An edge detected in the same cycle as a clearing write to its bit stays held.
- R8: The masked status word equals raw status AND enable.
- R9: `irq_o` is the OR of the masked bits whose route bit is 0. `fiq_o` is the OR of the masked bits whose route bit is 1.
- R10: Writes to the masked status word change no state. Reads at word indices 6 and 7 return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | 32 | Interrupt source lines, asynchronous |
| bus_en | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as the address |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
The hardest case to reach from the ports is an edge being detected in exactly the same clock as a write that clears its bit. The detection cycle lies three clock edges behind the input change, because the input first crosses the synchronizer and then the previous-sample flop. The stimulus therefore raises the source line and counts two clock edges. It then launches the clearing write so that the write lands on the third edge. The bench expects the flag to survive that collision.

// File: rtl/src_intc.sv
module src_intc #(
  parameter int N  = 32,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  src_i,
  input  logic          bus_en,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [N-1:0]  bus_wdata,
  output logic [N-1:0]  bus_rdata,
  output logic          irq_o,
  output logic          fiq_o
);
  localparam logic [AW-1:0] A_EN   = AW'(0);
  localparam logic [AW-1:0] A_RAW  = AW'(1);
  localparam logic [AW-1:0] A_MSK  = AW'(2);
  localparam logic [AW-1:0] A_POL  = AW'(3);
  localparam logic [AW-1:0] A_MODE = AW'(4);
  localparam logic [AW-1:0] A_ROUT = AW'(5);

  logic [N-1:0] en_q, pol_q, mode_q, rout_q;
  logic [N-1:0] s1_q, s2_q, s3_q, flag_q;
  logic [N-1:0] adj, adj_d, ev, clr, raw, masked;
  logic         wr_hit;

  assign wr_hit = bus_en & bus_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      pol_q  <= '0;
      mode_q <= '0;
      rout_q <= '0;
    end else if (wr_hit) begin
      case (bus_addr)
        A_EN:    en_q   <= bus_wdata;
        A_POL:   pol_q  <= bus_wdata;
        A_MODE:  mode_q <= bus_wdata;
        A_ROUT:  rout_q <= bus_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
      s3_q <= '0;
    end else begin
      s1_q <= src_i;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign adj   = ~(s2_q ^ pol_q);
  assign adj_d = ~(s3_q ^ pol_q);
  assign ev    = adj & ~adj_d & mode_q;
  assign clr   = (wr_hit && bus_addr == A_RAW) ? bus_wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= (flag_q & ~clr) | ev;
  end

  assign raw    = (mode_q & flag_q) | (~mode_q & adj);
  assign masked = raw & en_q;
  assign irq_o  = |(masked & ~rout_q);
  assign fiq_o  = |(masked & rout_q);

  always_comb begin
    case (bus_addr)
      A_EN:    bus_rdata = en_q;
      A_RAW:   bus_rdata = raw;
      A_MSK:   bus_rdata = masked;
      A_POL:   bus_rdata = pol_q;
      A_MODE:  bus_rdata = mode_q;
      A_ROUT:  bus_rdata = rout_q;
      default: bus_rdata = '0;
    endcase
  end

  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (en_q == '0 && pol_q == '0 && mode_q == '0 && rout_q == '0));

  assert_masked_silent_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == '0) |-> (!irq_o && !fiq_o));

  assert_flag_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flag_q & $past(flag_q & ~clr)) == $past(flag_q & ~clr)));

  assert_edge_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ev != '0) |=> ((flag_q & $past(ev)) == $past(ev)));

  assert_msk_write_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && bus_addr == A_MSK) |=>
      (en_q == $past(en_q) && pol_q == $past(pol_q) &&
       mode_q == $past(mode_q) && rout_q == $past(rout_q)));
endmodule

// File: tb/src_intc_test.sv
module src_intc_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [31:0] src_i = '0;
  logic        bus_en = 0, bus_wr = 0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_o, fiq_o;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  src_intc uut (.clk(clk), .rst_n(rst_n), .src_i(src_i), .bus_en(bus_en),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_o(irq_o), .fiq_o(fiq_o));

  localparam int NV = 5;
  localparam logic [31:0] V_SRC [NV] = '{32'h0000_00F0, 32'h0, 32'hFFFF_0000, 32'h1, 32'hAAAA_AAAA};
  localparam logic [31:0] V_EN  [NV] = '{32'hFFFF_FFFF, 32'hF, 32'hFFFF_FFFF, 32'h1, 32'h5555_5555};
  localparam logic [31:0] V_POL [NV] = '{32'hFFFF_FFFF, 32'h0, 32'hFFFF_0000, 32'hFFFF_FFFF, 32'hFFFF_FFFF};
  localparam logic [31:0] V_ROU [NV] = '{32'h0, 32'h0, 32'h8000_0000, 32'h1, 32'h0};
  localparam logic [31:0] V_RAW [NV] = '{32'h0000_00F0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h1, 32'hAAAA_AAAA};
  localparam logic [31:0] V_MSK [NV] = '{32'h0000_00F0, 32'hF, 32'hFFFF_FFFF, 32'h1, 32'h0};
  localparam logic [1:0]  V_OUT [NV] = '{2'b10, 2'b10, 2'b11, 2'b01, 2'b00};

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_en = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    #1 bus_en = 0; bus_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_en = 1; bus_wr = 0; bus_addr = a;
    #1 d = bus_rdata;
    bus_en = 0;
  endtask

  task automatic settle();
    repeat (4) @(posedge clk);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;

    rd(0, d); chk("R1 enable", d, 32'h0);
    rd(3, d); chk("R1 polarity", d, 32'h0);
    rd(4, d); chk("R1 mode", d, 32'h0);
    rd(5, d); chk("R1 route", d, 32'h0);
    chk("R1 outputs", {30'h0, irq_o, fiq_o}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      wr(0, V_EN[i]); wr(3, V_POL[i]); wr(5, V_ROU[i]);
      src_i = V_SRC[i];
      settle();
      rd(1, d); chk("R4 raw level", d, V_RAW[i]);
      rd(2, d); chk("R8 masked", d, V_MSK[i]);
      @(negedge clk);
      chk("R9 R3 outputs", {30'h0, irq_o, fiq_o}, {30'h0, V_OUT[i]});
    end

    wr(3, 32'h1234_5678); rd(3, d); chk("R2 polarity readback", d, 32'h1234_5678);
    wr(5, 32'h0F0F_0000); rd(5, d); chk("R2 route readback", d, 32'h0F0F_0000);

    src_i = 32'h0000_0020;
    wr(0, 32'h10); wr(3, 32'h10); wr(5, 32'h0); wr(4, 32'h30);
    settle();
    wr(1, 32'hFFFF_FFFF);
    rd(1, d); chk("R5 edge idle", d & 32'h30, 32'h0);
    src_i[4] = 1;
    settle();
    rd(1, d); chk("R5 rising latched", d & 32'h30, 32'h10);
    @(negedge clk); chk("R9 irq from edge", {31'h0, irq_o}, 32'h1);
    src_i[4] = 0;
    settle();
    rd(1, d); chk("R5 held after drop", d & 32'h10, 32'h10);
    wr(1, 32'hFFFF_FFEF);
    rd(1, d); chk("R6 zero write no effect", d & 32'h10, 32'h10);
    wr(1, 32'h10);
    rd(1, d); chk("R6 cleared", d & 32'h10, 32'h0);
    @(negedge clk); chk("R6 irq dropped", {31'h0, irq_o}, 32'h0);
    src_i[5] = 0;
    settle();
    rd(1, d); chk("R5 falling latched", d & 32'h20, 32'h20);

    @(negedge clk) src_i[4] = 1;
    @(posedge clk);
    @(posedge clk);
    wr(1, 32'h10);
    rd(1, d); chk("R7 edge beats clear", d & 32'h10, 32'h10);

    wr(2, 32'h0);
    rd(0, d); chk("R10 enable kept", d, 32'h10);
    rd(2, d); chk("R10 masked kept", d, 32'h10);
    wr(6, 32'hFFFF_FFFF);
    rd(6, d); chk("R10 unmapped 6", d, 32'h0);
    rd(7, d); chk("R10 unmapped 7", d, 32'h0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule